// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block holds the status and control word of one USB host (or dual-role) port and runs the small state machines behind its control bits. Software reads and writes the word over a plain register strobe. The block turns those writes into a timed bus-reset interval, a port-enable state and a suspend state. It also exposes a gate that stops downstream traffic while the port is suspended.

Port power gates everything else. While power is off, the port reports no attach, is not enabled and cannot be reset or suspended. Each of the following needs a single write:

- **Bus reset.** Writing the reset bit starts the reset interval. The bit clears itself when a parameterised counter expires, and the port then becomes enabled if a device is attached.
- **Suspend.** A suspend request waits for any transaction in progress to finish.
- **Resume.** A resume event sets the force-resume bit. Suspend ends when software clears that bit again.

In device mode, the reset bit simply reports a bus reset seen from upstream. A build without host capability has no power control.

Top module: `usbp_portctl`

## Requirements
- R1: After reset, every register bit reads 0 except the line-status field, and the outputs bus_reset_drive, port_enabled, port_suspended and downstream_block are 0.
- R2: Bits [8:7] always mirror {line_dp, line_dm}; 2'b00 is SE0, 2'b10 is J, 2'b01 is K, 2'b11 is undefined.
- R3: Bit 6 is port power, written directly by software. While it reads 0 in host mode, the following all read 0: attach (bit 0), enable (bit 1), suspend (bit 4) and reset (bit 5). Writing 0 to power clears the reset, enable, suspend and force-resume state in the same cycle.
- R4: In host mode with power on, writing 1 to bit 5 makes bit 5 and bus_reset_drive read 1 for exactly RST_CYCLES cycles after the write edge. Both then return to 0 with no further write.
- R5: When the reset interval ends, bit 1 (enable) takes the value of attach_in. Enable drops as soon as attach_in goes low.
- R6: In device mode, bit 5 reflects dev_bus_reset, bit 4 reads 0, and writes to bits 5 and 4 have no effect.
- R7: A write of 1 to bit 4 while enabled and with xact_busy low sets bit 4 at that edge. The pair {bit 1, bit 4} reads 2'b11 when suspended, 2'b10 when enabled and 2'b0x when disabled.
- R8: A suspend request made while xact_busy is high leaves bit 4 at 0 until xact_busy is seen low, and bit 4 sets at that edge.
- R9: While suspended, downstream_block is 1. A write of 1 to bit 5 still starts a bus reset, which clears suspend.
- R10: Writing 0 to bit 4 has no effect. resume_det while suspended sets bit 3 (force resume). A software write that clears bit 3 from 1 clears suspend at that edge.
- R11: A suspend request while the port is disabled is ignored, and bit 4 stays 0.
- R12: A high oc_in sets sticky bit 2 at the next edge; writing 1 to bit 2 clears it unless oc_in is high in that cycle. Over-current never changes port power.
- R13: With HOST_CAPABLE = 0, bit 6 reads 0, bit 5 follows only dev_bus_reset, and writes to the power and reset bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = port acts as host, 0 = device |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Register write value |
| rd_data | output | 9 | Register read value |
| line_dp | input | 1 | Logical level of D+ |
| line_dm | input | 1 | Logical level of D- |
| attach_in | input | 1 | A device is attached |
| xact_busy | input | 1 | A transaction is in progress downstream |
| oc_in | input | 1 | Over-current detected |
| resume_det | input | 1 | Resume signalling detected |
| dev_bus_reset | input | 1 | Bus reset seen from upstream in device mode |
| bus_reset_drive | output | 1 | Bus-reset interval in progress |
| port_enabled | output | 1 | Port is enabled |
| port_suspended | output | 1 | Port is suspended |
| downstream_block | output | 1 | Downstream traffic must be held off |

## Verification
The bench builds the main instance with RST_CYCLES = 8, which lets every reset interval be counted edge by edge and keeps back-to-back reset, suspend and resume sequences short. A second instance, with HOST_CAPABLE = 0 and the same inputs, places the device-only build beside the host build in every stimulus. Random line levels and random over-current pulses with interleaved clear writes are checked against a bench model, and directed sequences cover a suspend held back by a busy transaction and a reset during suspend.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  localparam int REG_W  = 9;
  localparam int B_CONN = 0;
  localparam int B_PE   = 1;
  localparam int B_OC   = 2;
  localparam int B_FPR  = 3;
  localparam int B_SUSP = 4;
  localparam int B_PR   = 5;
  localparam int B_PP   = 6;
  localparam int B_LSM  = 7;
  localparam int B_LSP  = 8;

  typedef enum logic [1:0] {
    LS_SE0   = 2'b00,
    LS_K     = 2'b01,
    LS_J     = 2'b10,
    LS_UNDEF = 2'b11
  } line_e;

  function automatic line_e line_of(input logic dp, input logic dm);
    return line_e'({dp, dm});
  endfunction

  function automatic logic [REG_W-1:0] pack_status(
    input logic conn, input logic pe, input logic oc, input logic fpr,
    input logic susp, input logic pr, input logic pp, input line_e ls);
    logic [REG_W-1:0] v;
    v = '0;
    v[B_CONN] = conn;
    v[B_PE]   = pe;
    v[B_OC]   = oc;
    v[B_FPR]  = fpr;
    v[B_SUSP] = susp;
    v[B_PR]   = pr;
    v[B_PP]   = pp;
    v[B_LSP:B_LSM] = ls;
    return v;
  endfunction
endpackage

// File: rtl/usbp_rst_timer.sv
module usbp_rst_timer #(
  parameter int CYCLES = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          run;

  assign done = run & (cnt == LAST);
  assign busy = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (abort) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usbp_susp_ctl.sv
module usbp_susp_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic enabled,
  input  logic req,
  input  logic xact_busy,
  input  logic resume_release,
  output logic suspended
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      suspended <= 1'b0;
      pending   <= 1'b0;
    end else if (kill || resume_release || !enabled) begin
      suspended <= 1'b0;
      pending   <= 1'b0;
    end else if (req && !suspended) begin
      suspended <= !xact_busy;
      pending   <= xact_busy;
    end else if (pending && !xact_busy) begin
      suspended <= 1'b1;
      pending   <= 1'b0;
    end
  end
endmodule

// File: rtl/usbp_portctl.sv
module usbp_portctl
  import usbp_pkg::*;
#(
  parameter bit HOST_CAPABLE = 1'b1,
  parameter int RST_CYCLES   = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             line_dp,
  input  logic             line_dm,
  input  logic             attach_in,
  input  logic             xact_busy,
  input  logic             oc_in,
  input  logic             resume_det,
  input  logic             dev_bus_reset,
  output logic             bus_reset_drive,
  output logic             port_enabled,
  output logic             port_suspended,
  output logic             downstream_block
);
  logic pwr_q, pwr_nxt;
  logic host_eff, host_act, host_act_nxt;
  logic rst_start, tmr_busy, tmr_done;
  logic enabled_q, susp_req, susp_kill;
  logic fpr_q, fpr_fall, resume_set;
  logic oc_q;

  // Power bit exists only in a host-capable build.
  generate
    if (HOST_CAPABLE) begin : g_pwr
      assign pwr_nxt = wr_en ? wr_data[B_PP] : pwr_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pwr_q <= 1'b0;
        else        pwr_q <= pwr_nxt;
      end
    end else begin : g_nopwr
      assign pwr_nxt = 1'b0;
      assign pwr_q   = 1'b0;
    end
  endgenerate

  assign host_eff     = host_mode & HOST_CAPABLE;
  assign host_act     = host_eff & pwr_q;
  assign host_act_nxt = host_eff & pwr_nxt;

  // Bus-reset sequencing.
  assign rst_start = host_act_nxt & wr_en & wr_data[B_PR] & ~tmr_busy;

  usbp_rst_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rst_start),
    .abort (~host_act_nxt),
    .busy  (tmr_busy),
    .done  (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)              enabled_q <= 1'b0;
    else if (!host_act_nxt)  enabled_q <= 1'b0;
    else if (rst_start)      enabled_q <= 1'b0;
    else if (tmr_done)       enabled_q <= attach_in;
    else if (!attach_in)     enabled_q <= 1'b0;
  end

  // Force-resume bit and suspend sequencing.
  assign resume_set = port_suspended & resume_det;
  assign fpr_fall   = host_act_nxt & fpr_q & wr_en & ~wr_data[B_FPR] & ~resume_set;

  always_ff @(posedge clk) begin
    if (!rst_n)                         fpr_q <= 1'b0;
    else if (!host_act_nxt || rst_start) fpr_q <= 1'b0;
    else if (resume_set)                fpr_q <= 1'b1;
    else if (wr_en)                     fpr_q <= wr_data[B_FPR];
  end

  assign susp_req  = host_act & wr_en & wr_data[B_SUSP] & ~rst_start;
  assign susp_kill = ~host_act_nxt | rst_start | ~attach_in;

  usbp_susp_ctl u_susp_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .kill           (susp_kill),
    .enabled        (enabled_q),
    .req            (susp_req),
    .xact_busy      (xact_busy),
    .resume_release (fpr_fall),
    .suspended      (port_suspended)
  );

  // Sticky over-current: set wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_in | (oc_q & ~(wr_en & wr_data[B_OC]));
  end

  assign bus_reset_drive  = tmr_busy & host_act;
  assign port_enabled     = enabled_q;
  assign downstream_block = port_suspended;

  assign rd_data = pack_status(
    attach_in & (pwr_q | ~host_eff),
    enabled_q,
    oc_q,
    fpr_q,
    port_suspended,
    host_eff ? (tmr_busy & pwr_q) : dev_bus_reset,
    pwr_q,
    line_of(line_dp, line_dm));
endmodule

module usbp_portctl_chk
  import usbp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rd_data,
  input logic             bus_reset_drive,
  input logic             port_enabled,
  input logic             port_suspended,
  input logic             xact_busy,
  input logic             oc_in,
  input logic             fpr_fall
);
  // R3
  pwr_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_PP] |-> (!bus_reset_drive && !port_enabled && !port_suspended));

  // R7
  susp_implies_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_suspended |-> port_enabled);

  // R8
  susp_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_suspended) |-> !$past(xact_busy));

  // R11
  susp_from_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_suspended) |-> $past(port_enabled));

  // R4
  reset_excludes_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_drive |-> (!port_suspended && !port_enabled));

  // R10
  resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fpr_fall |=> !port_suspended);

  // R12
  oc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_in |=> rd_data[B_OC]);
endmodule

bind usbp_portctl usbp_portctl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rd_data         (rd_data),
  .bus_reset_drive (bus_reset_drive),
  .port_enabled    (port_enabled),
  .port_suspended  (port_suspended),
  .xact_busy       (xact_busy),
  .oc_in           (oc_in),
  .fpr_fall        (fpr_fall)
);

// File: tb/usbp_portctl_test.sv
`timescale 1ns/1ps
module usbp_portctl_test;
  localparam int RC = 8;
  localparam logic [8:0] W_OC = 9'h004, W_FPR = 9'h008, W_SUSP = 9'h010,
                         W_PR = 9'h020, W_PP  = 9'h040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_mode = 1'b1, wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic line_dp = 1'b1, line_dm = 1'b0;
  logic attach_in = 1'b0, xact_busy = 1'b0, oc_in = 1'b0;
  logic resume_det = 1'b0, dev_bus_reset = 1'b0;
  logic [8:0] rd_data, rd_dev;
  logic bus_reset_drive, port_enabled, port_suspended, downstream_block;
  logic drv_dev, en_dev, susp_dev, blk_dev;
  int total = 0, bad = 0;
  logic e_oc;

  always #2 clk = ~clk;

  usbp_portctl #(.HOST_CAPABLE(1'b1), .RST_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .line_dp(line_dp), .line_dm(line_dm),
    .attach_in(attach_in), .xact_busy(xact_busy), .oc_in(oc_in),
    .resume_det(resume_det), .dev_bus_reset(dev_bus_reset),
    .bus_reset_drive(bus_reset_drive), .port_enabled(port_enabled),
    .port_suspended(port_suspended), .downstream_block(downstream_block));

  usbp_portctl #(.HOST_CAPABLE(1'b0), .RST_CYCLES(RC)) uut_devonly (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_dev), .line_dp(line_dp), .line_dm(line_dm),
    .attach_in(attach_in), .xact_busy(xact_busy), .oc_in(oc_in),
    .resume_det(resume_det), .dev_bus_reset(dev_bus_reset),
    .bus_reset_drive(drv_dev), .port_enabled(en_dev),
    .port_suspended(susp_dev), .downstream_block(blk_dev));

  // Bench's own view of the register word: D+ on top, attach at the bottom.
  function automatic logic [8:0] exp_rd(input logic conn, input logic pe,
      input logic oc, input logic fpr, input logic susp, input logic pr,
      input logic pp);
    return {line_dp, line_dm, pp, pr, susp, fpr, oc, pe, conn};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 reg", rd_data, exp_rd(0,0,0,0,0,0,0));
    check("R1 outs", {bus_reset_drive, port_enabled, port_suspended, downstream_block}, 0);

    // R2: random line levels
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      line_dp = 1'($urandom);
      line_dm = 1'($urandom);
      #1;
      check("R2 line", rd_data[8:7], {line_dp, line_dm});
    end
    line_dp = 1'b1; line_dm = 1'b0;
    #1;
    check("R2 J", rd_data[8:7], 2'b10);

    // R3: attach hidden while unpowered, shown after power on
    attach_in = 1'b1;
    @(negedge clk);
    check("R3 unpowered", rd_data, exp_rd(0,0,0,0,0,0,0));
    do_write(W_PP);
    check("R3 powered", rd_data, exp_rd(1,0,0,0,0,0,1));
    check("R13 no power", rd_dev, exp_rd(1,0,0,0,0,0,0));

    // R11: suspend while disabled
    do_write(W_PP | W_SUSP);
    check("R11 ignored", rd_data, exp_rd(1,0,0,0,0,0,1));
    @(negedge clk);
    check("R11 later", port_suspended, 0);

    // R4 / R5: timed reset
    do_write(W_PP | W_PR);
    check("R4 start", rd_data, exp_rd(1,0,0,0,0,1,1));
    check("R4 drive", bus_reset_drive, 1);
    check("R13 no reset", {rd_dev[5], drv_dev}, 0);
    repeat (RC-1) @(negedge clk);
    check("R4 last cycle", {rd_data[5], bus_reset_drive}, 2'b11);
    @(negedge clk);
    check("R4 R5 end", rd_data, exp_rd(1,1,0,0,0,0,1));
    check("R4 drive off", bus_reset_drive, 0);

    // R7 / R9: immediate suspend
    do_write(W_PP | W_SUSP);
    check("R7 suspended", rd_data, exp_rd(1,1,0,0,1,0,1));
    check("R9 block", downstream_block, 1);

    // R10: write 0 ignored, resume sets force-resume, clearing it ends suspend
    do_write(W_PP);
    check("R10 zero write", rd_data[4], 1);
    @(negedge clk); resume_det = 1'b1;
    @(negedge clk); resume_det = 1'b0;
    check("R10 resume", rd_data, exp_rd(1,1,0,1,1,0,1));
    do_write(W_PP | W_FPR);
    check("R10 hold", rd_data, exp_rd(1,1,0,1,1,0,1));
    do_write(W_PP);
    check("R10 release", rd_data, exp_rd(1,1,0,0,0,0,1));
    check("R10 unblock", downstream_block, 0);

    // R8: deferred suspend
    xact_busy = 1'b1;
    do_write(W_PP | W_SUSP);
    check("R8 deferred", rd_data[4], 0);
    repeat (3) @(negedge clk);
    check("R8 still busy", rd_data[4], 0);
    xact_busy = 1'b0;
    @(negedge clk);
    check("R8 takes effect", rd_data, exp_rd(1,1,0,0,1,0,1));

    // R9: reset during suspend, no device at the end
    do_write(W_PP | W_PR);
    check("R9 reset in suspend", rd_data, exp_rd(1,0,0,0,0,1,1));
    attach_in = 1'b0;
    repeat (RC) @(negedge clk);
    check("R5 no device", rd_data, exp_rd(0,0,0,0,0,0,1));
    attach_in = 1'b1;
    @(negedge clk);
    check("R5 stays disabled", rd_data, exp_rd(1,0,0,0,0,0,1));

    // R5: detach drops enable
    do_write(W_PP | W_PR);
    repeat (RC) @(negedge clk);
    check("R5 enabled", port_enabled, 1);
    attach_in = 1'b0;
    @(negedge clk);
    check("R5 detach", port_enabled, 0);
    attach_in = 1'b1;
    do_write(W_PP | W_PR);
    repeat (RC) @(negedge clk);

    // R12: random over-current with clears
    e_oc = 1'b0;
    for (int i = 0; i < 40; i++) begin
      logic o, c;
      o = ($urandom % 4) == 0;
      c = ($urandom % 3) == 0;
      oc_in = o;
      wr_en = c;
      wr_data = W_PP | (c ? W_OC : 9'h000);
      @(negedge clk);
      e_oc = o | (e_oc & ~c);
      check("R12 sticky", rd_data[2], e_oc);
      check("R12 power kept", rd_data[6], 1);
    end
    oc_in = 1'b1; wr_en = 1'b1; wr_data = W_PP | W_OC;
    @(negedge clk);
    oc_in = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R12 set wins", rd_data[2], 1);
    do_write(W_PP | W_OC);
    check("R12 cleared", rd_data[2], 0);

    // R3: power off from suspend
    do_write(W_PP | W_SUSP);
    check("R3 pre", port_suspended, 1);
    do_write(9'h000);
    check("R3 off reg", rd_data, exp_rd(0,0,0,0,0,0,0));
    check("R3 off outs", {bus_reset_drive, port_enabled, port_suspended, downstream_block}, 0);

    // R6: device mode
    host_mode = 1'b0;
    do_write(W_PP);
    dev_bus_reset = 1'b1;
    #1;
    check("R6 reset seen", rd_data[5], 1);
    check("R13 dev reset seen", rd_dev[5], 1);
    dev_bus_reset = 1'b0;
    do_write(W_PP | W_PR | W_SUSP);
    check("R6 writes ignored", rd_data, exp_rd(1,0,0,0,0,0,1));
    check("R6 no drive", {bus_reset_drive, port_suspended}, 0);

    finish_up();
  end
endmodule